// File: doc/BRIEF.md
# Interrupt Destination Address Matcher

This block decides, for one local interrupt controller, whether an interrupt command is addressed to it. A command arrives as a low word and a high word. The low word carries the destination mode and the shorthand field. The high word carries the destination. A separate flag tells the block whether the sender is this controller. The answer is registered and appears one cycle after the command, together with a valid strobe. The block also keeps a copy of the low word and of the high word as they read back after a command write.

The block holds three addressing registers: the local ID, the logical destination register and the model-select register. Writes to these registers are masked. While the extended-addressing flag is high, writes to them are refused, and the logical register that the block reads and uses is derived from the local ID. Arbitration among several targets and the actual delivery belong to other logic.

Top module: `irq_dest_match`

## Requirements
- R1: The shorthand is `cmd_lo_i[19:18]`, encoded as 00 none, 01 self, 10 everyone, 11 everyone-but-sender. Self matches only when `sender_self_i` is 1. Everyone always matches. Everyone-but-sender matches only when `sender_self_i` is 0.
- R2: With shorthand none and `cmd_lo_i[11]`=0 (physical), the match is 1 when the destination equals 0xFF or equals the local ID held in `id_o[31:24]`. The destination is `cmd_hi_i[31:24]` in legacy mode and the whole of `cmd_hi_i` in extended mode, compared against the ID extended with zeros.
- R3: With shorthand none, `cmd_lo_i[11]`=1 (logical) and legacy mode, a model-select top nibble of 0xF picks the flat model. The match is 1 when `logical_o[31:24] & cmd_hi_i[31:24]` is nonzero.
- R4: A model-select top nibble of 0x0 picks the cluster model. A logical match then needs the upper nibbles of the logical ID and of the destination to be equal, and the AND of their lower nibbles to be nonzero.
- R5: Any other model-select top nibble gives no logical match in legacy mode.
- R6: In extended mode, `logical_o` reads `((id & 0xF0) << 16) | (1 << id[3:0])`, where id is `id_o[31:24]`. A logical command matches when that value ANDed with all 32 bits of `cmd_hi_i` is nonzero.
- R7: After reset, `id_o`=0, `logical_o`=0 and `format_o`=0xFFFFFFFF. Register select `reg_sel_i` is encoded 0 ID, 1 logical, 2 model-select, 3 none. An ID or logical write keeps only bits 31:24. A model-select write stores the written value ORed with 0x0FFFFFFF.
- R8: While `ext_mode_i` is 1, register writes leave all three registers unchanged.
- R9: After a command, `cmd_lo_o` holds `cmd_lo_i` with bit 12 forced to 0. `dest_o` holds `cmd_hi_i` with bits 23:0 cleared in legacy mode, and the whole of `cmd_hi_i` in extended mode.
- R10: `match_valid_o` is 1 exactly one cycle after `cmd_valid_i`. Otherwise it is 0, and `match_o` is 0 whenever `match_valid_o` is 0.
- R11: When a register write and a command fall in the same cycle, the command is judged against the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | Extended addressing mode |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| cmd_valid_i | input | 1 | Command present |
| cmd_lo_i | input | 32 | Command low word |
| cmd_hi_i | input | 32 | Command high word (destination) |
| sender_self_i | input | 1 | Sender is this controller |
| match_valid_o | output | 1 | Result valid |
| match_o | output | 1 | This controller is a target |
| cmd_lo_o | output | 32 | Captured low word |
| dest_o | output | 32 | Captured destination word |
| id_o | output | 32 | Local ID register |
| logical_o | output | 32 | Effective logical register |
| format_o | output | 32 | Model-select register |

## Verification
A register write and a command can land on the same clock edge. The bench provokes this by rewriting the local ID in the very cycle a physical command addresses the old ID. The scoreboard expects a hit computed from the bench's shadow of the registers before the write. The bench then sends the same command again and expects a miss, which confirms that the new ID took effect one cycle later.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
  localparam int DATA_W   = 32;
  localparam int ID_W     = 8;
  localparam int NIB_W    = 4;
  localparam int NREG     = 3;
  localparam int SH_LSB   = 18;
  localparam int DM_BIT   = 11;
  localparam int DS_BIT   = 12;
  localparam int CL_SHIFT = 16;
  localparam logic [ID_W-1:0]  BCAST     = '1;
  localparam logic [NIB_W-1:0] NIB_FLAT  = '1;
  localparam logic [NIB_W-1:0] NIB_CLUST = '0;

  typedef enum logic [1:0] {SH_NONE, SH_SELF, SH_ALL, SH_OTHERS} shorthand_e;
  typedef enum logic [1:0] {SEL_ID, SEL_LOG, SEL_FMT, SEL_NONE} reg_sel_e;
endpackage

// File: rtl/idm_regs.sv
module idm_regs
  import irq_dest_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_i,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] id_q_o,
  output logic [DATA_W-1:0] log_q_o,
  output logic [DATA_W-1:0] fmt_q_o
);
  localparam logic [DATA_W-1:0] TOP_BYTE = {{ID_W{1'b1}}, {(DATA_W-ID_W){1'b0}}};
  localparam logic [DATA_W-1:0] TOP_NIB  = {{NIB_W{1'b1}}, {(DATA_W-NIB_W){1'b0}}};
  localparam logic [DATA_W-1:0] KEEP  [NREG] = '{TOP_BYTE, TOP_BYTE, TOP_NIB};
  localparam logic [DATA_W-1:0] FILL  [NREG] = '{'0, '0, ~TOP_NIB};
  localparam logic [DATA_W-1:0] RST_V [NREG] = '{'0, '0, '1};

  logic [DATA_W-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[g] <= RST_V[g];
      else if (we_i && !ext_i && sel_i == 2'(g)) q[g] <= (wdata_i & KEEP[g]) | FILL[g];
    end
  end

  assign id_q_o  = q[SEL_ID];
  assign log_q_o = q[SEL_LOG];
  assign fmt_q_o = q[SEL_FMT];

  // R8: extended mode locks the register bank
  p_ext_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_i && we_i) |=> ($stable(id_q_o) && $stable(log_q_o) && $stable(fmt_q_o)));
endmodule

// File: rtl/idm_logical.sv
module idm_logical
  import irq_dest_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [DATA_W-1:0] log_q_i,
  input  logic [DATA_W-1:0] fmt_q_i,
  input  logic [DATA_W-1:0] dest_i,
  output logic [DATA_W-1:0] log_eff_o,
  output logic              hit_o
);
  localparam logic [ID_W-1:0] ID_HI = {{(ID_W-NIB_W){1'b1}}, {NIB_W{1'b0}}};

  logic [DATA_W-1:0] derived;
  logic [ID_W-1:0]   lid, ldst;
  logic [NIB_W-1:0]  model;
  logic              flat_hit, clus_hit;

  assign derived = (DATA_W'(id_i & ID_HI) << CL_SHIFT) | (DATA_W'(1) << id_i[NIB_W-1:0]);
  assign log_eff_o = ext_i ? derived : log_q_i;

  assign lid   = log_q_i[DATA_W-1 -: ID_W];
  assign ldst  = dest_i[ID_W-1:0];
  assign model = fmt_q_i[DATA_W-1 -: NIB_W];

  assign flat_hit = |(lid & ldst);
  assign clus_hit = (lid[ID_W-1:NIB_W] == ldst[ID_W-1:NIB_W]) &&
                    |(lid[NIB_W-1:0] & ldst[NIB_W-1:0]);

  always_comb begin
    hit_o = 1'b0;
    if (ext_i)                   hit_o = |(derived & dest_i);
    else if (model == NIB_FLAT)  hit_o = flat_hit;
    else if (model == NIB_CLUST) hit_o = clus_hit;
  end

  // R5: unknown model never matches in legacy mode
  p_bad_model_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_i && model != NIB_FLAT && model != NIB_CLUST) |-> !hit_o);
  // R4: cluster hit needs equal upper nibbles
  p_cluster_grp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_i && model == NIB_CLUST && hit_o) |-> (lid[ID_W-1:NIB_W] == ldst[ID_W-1:NIB_W]));
endmodule

// File: rtl/idm_target.sv
module idm_target
  import irq_dest_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        sh_i,
  input  logic              logical_i,
  input  logic              self_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [DATA_W-1:0] dest_i,
  input  logic              log_hit_i,
  output logic              hit_o
);
  logic phys_hit;

  assign phys_hit = (dest_i == DATA_W'(BCAST)) || (dest_i == DATA_W'(id_i));

  always_comb begin
    unique case (shorthand_e'(sh_i))
      SH_SELF:   hit_o = self_i;
      SH_ALL:    hit_o = 1'b1;
      SH_OTHERS: hit_o = !self_i;
      default:   hit_o = logical_i ? log_hit_i : phys_hit;
    endcase
  end

  // R2: broadcast in physical mode always hits
  p_bcast_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_i == SH_NONE && !logical_i && dest_i == DATA_W'(BCAST)) |-> hit_o);
endmodule

// File: rtl/irq_dest_match.sv
module irq_dest_match
  import irq_dest_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_mode_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              cmd_valid_i,
  input  logic [DATA_W-1:0] cmd_lo_i,
  input  logic [DATA_W-1:0] cmd_hi_i,
  input  logic              sender_self_i,
  output logic              match_valid_o,
  output logic              match_o,
  output logic [DATA_W-1:0] cmd_lo_o,
  output logic [DATA_W-1:0] dest_o,
  output logic [DATA_W-1:0] id_o,
  output logic [DATA_W-1:0] logical_o,
  output logic [DATA_W-1:0] format_o
);
  localparam logic [DATA_W-1:0] DS_MASK  = DATA_W'(1) << DS_BIT;
  localparam logic [DATA_W-1:0] LEG_DEST = {{ID_W{1'b1}}, {(DATA_W-ID_W){1'b0}}};

  logic [DATA_W-1:0] id_q, log_q, fmt_q, dest_cmp, log_eff;
  logic [ID_W-1:0]   lid;
  logic              log_hit, hit;
  logic              valid_q, match_q;
  logic [DATA_W-1:0] lo_q, dest_q;

  idm_regs u_regs (
    .clk_i, .rst_ni, .ext_i(ext_mode_i), .we_i(reg_we_i), .sel_i(reg_sel_i),
    .wdata_i(reg_wdata_i), .id_q_o(id_q), .log_q_o(log_q), .fmt_q_o(fmt_q)
  );

  assign lid      = id_q[DATA_W-1 -: ID_W];
  assign dest_cmp = ext_mode_i ? cmd_hi_i : DATA_W'(cmd_hi_i[DATA_W-1 -: ID_W]);

  idm_logical u_logical (
    .clk_i, .rst_ni, .ext_i(ext_mode_i), .id_i(lid), .log_q_i(log_q),
    .fmt_q_i(fmt_q), .dest_i(dest_cmp), .log_eff_o(log_eff), .hit_o(log_hit)
  );

  idm_target u_target (
    .clk_i, .rst_ni, .sh_i(cmd_lo_i[SH_LSB +: 2]), .logical_i(cmd_lo_i[DM_BIT]),
    .self_i(sender_self_i), .id_i(lid), .dest_i(dest_cmp), .log_hit_i(log_hit),
    .hit_o(hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      match_q <= 1'b0;
      lo_q    <= '0;
      dest_q  <= '0;
    end else begin
      valid_q <= cmd_valid_i;
      match_q <= cmd_valid_i && hit;
      if (cmd_valid_i) begin
        lo_q   <= cmd_lo_i & ~DS_MASK;
        dest_q <= ext_mode_i ? cmd_hi_i : (cmd_hi_i & LEG_DEST);
      end
    end
  end

  assign match_valid_o = valid_q;
  assign match_o       = match_q;
  assign cmd_lo_o      = lo_q;
  assign dest_o        = dest_q;
  assign id_o          = id_q;
  assign logical_o     = log_eff;
  assign format_o      = fmt_q;

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> (!match_valid_o && !match_o));
  p_all_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_lo_i[SH_LSB +: 2] == SH_ALL) |=> match_o);
  p_self_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_lo_i[SH_LSB +: 2] == SH_SELF && !sender_self_i) |=> !match_o);
  p_status_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> (!cmd_lo_o[DS_BIT] && cmd_lo_o[DS_BIT-1:0] == $past(cmd_lo_i[DS_BIT-1:0])));
endmodule

// File: tb/irq_dest_match_bench.sv
module irq_dest_match_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ext = 1'b0, we = 1'b0, cv = 1'b0, self_f = 1'b0;
  logic [1:0]  sel = 2'd3;
  logic [31:0] wd = '0, lo = '0, hi = '0;
  logic        mv, mo;
  logic [31:0] lo_o, dest_o, id_o, log_o, fmt_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit          exp_q[$];
  string       tag_q[$];
  logic [31:0] s_id = '0, s_lg = '0, s_fm = 32'hFFFF_FFFF;

  always #2 clk = ~clk;

  irq_dest_match u_irq_dest_match (
    .clk_i(clk), .rst_ni(rst_n), .ext_mode_i(ext), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wd), .cmd_valid_i(cv), .cmd_lo_i(lo), .cmd_hi_i(hi),
    .sender_self_i(self_f), .match_valid_o(mv), .match_o(mo), .cmd_lo_o(lo_o),
    .dest_o(dest_o), .id_o(id_o), .logical_o(log_o), .format_o(fmt_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] derive(logic [7:0] id);
    return ({24'h0, id & 8'hF0} << 16) | (32'h1 << id[3:0]);
  endfunction

  function automatic bit model(logic [31:0] l, logic [31:0] h, bit s, bit x,
                               logic [31:0] idr, logic [31:0] lgr, logic [31:0] fmr);
    logic [31:0] d;
    logic [7:0] a, b;
    case (l[19:18])
      2'b01: return s;
      2'b10: return 1'b1;
      2'b11: return !s;
      default: ;
    endcase
    d = x ? h : {24'h0, h[31:24]};
    if (!l[11]) return (d == 32'hFF) || (d == {24'h0, idr[31:24]});
    if (x) return |(derive(idr[31:24]) & h);
    a = lgr[31:24];
    b = h[31:24];
    if (fmr[31:28] == 4'hF) return |(a & b);
    if (fmr[31:28] == 4'h0) return (a[7:4] == b[7:4]) && |(a[3:0] & b[3:0]);
    return 1'b0;
  endfunction

  task automatic shadow_write(logic [1:0] s, logic [31:0] d);
    if (ext) return;
    case (s)
      2'd0: s_id = d & 32'hFF00_0000;
      2'd1: s_lg = d & 32'hFF00_0000;
      2'd2: s_fm = d | 32'h0FFF_FFFF;
      default: ;
    endcase
  endtask

  task automatic chk_regs(string req);
    chk({req, " id"}, id_o, s_id);
    chk({req, " logical"}, log_o, ext ? derive(s_id[31:24]) : s_lg);
    chk({req, " format"}, fmt_o, s_fm);
  endtask

  // called at a falling edge; returns at the next one
  task automatic wr(logic [1:0] s, logic [31:0] d, string req);
    we = 1'b1; sel = s; wd = d; cv = 1'b0;
    @(negedge clk);
    we = 1'b0;
    shadow_write(s, d);
    chk_regs(req);
  endtask

  task automatic send(logic [31:0] l, logic [31:0] h, bit s, string req);
    cv = 1'b1; lo = l; hi = h; self_f = s;
    exp_q.push_back(model(l, h, s, ext, s_id, s_lg, s_fm));
    tag_q.push_back(req);
    @(negedge clk);
    chk({req, " R9 lo"}, lo_o, l & ~32'h1000);
    chk({req, " R9 dest"}, dest_o, ext ? h : (h & 32'hFF00_0000));
  endtask

  task automatic idle();
    cv = 1'b0; we = 1'b0;
    @(negedge clk);
    chk("R10 idle valid", {31'h0, mv}, 32'h0);
    chk("R10 idle match", {31'h0, mo}, 32'h0);
  endtask

  // monitor: compare results against the scoreboard
  always @(negedge clk) begin
    if (rst_n && mv) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected result actual=%0d expected=none", mo);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (mo !== e) begin
          errors++;
          $display("FAIL %s actual=%0d expected=%0d", t, mo, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] PHYS = 32'h0000_0030;
  localparam logic [31:0] LOGI = 32'h0000_0830;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_regs("R7 reset");
    chk("R10 reset valid", {31'h0, mv}, 32'h0);

    wr(2'd0, 32'h05AB_CDEF, "R7 id mask");
    wr(2'd1, 32'h2C12_3456, "R7 logical mask");
    wr(2'd2, 32'h0000_1234, "R7 format fill");
    wr(2'd3, 32'hDEAD_BEEF, "R7 no select");

    // physical, back to back; bit 12 set to exercise status clearing
    send(PHYS | 32'h1000, 32'h0512_3456, 0, "R2 own id");
    send(PHYS, 32'h0600_0000, 0, "R2 other id");
    send(PHYS | 32'h1000, 32'hFF00_0000, 0, "R2 broadcast");
    idle();

    // cluster model: logical id 0x2C
    send(LOGI, 32'h2400_0000, 0, "R4 cluster hit");
    send(LOGI, 32'h2100_0000, 0, "R4 cluster no bits");
    send(LOGI, 32'h3400_0000, 0, "R4 cluster other group");
    idle();

    wr(2'd2, 32'hF000_0000, "R7 flat select");
    send(LOGI, 32'h0400_0000, 0, "R3 flat hit");
    send(LOGI, 32'h1000_0000, 0, "R3 flat miss");
    send(LOGI, 32'h2000_0000, 0, "R3 flat hit2");

    wr(2'd2, 32'h5000_0000, "R7 bad model");
    send(LOGI, 32'h2C00_0000, 0, "R5 bad model logical");
    send(PHYS, 32'h0500_0000, 0, "R5 physical still");

    // shorthands, destination deliberately unmatched
    send(32'h0004_0000, 32'h7700_0000, 1, "R1 self from self");
    send(32'h0004_0000, 32'h7700_0000, 0, "R1 self from other");
    send(32'h0008_0000, 32'h7700_0000, 0, "R1 everyone");
    send(32'h000C_0000, 32'h0500_0000, 1, "R1 others from self");
    send(32'h000C_0000, 32'h7700_0000, 0, "R1 others from other");
    idle();

    // R11: id rewrite in the same cycle as a command to the old id
    we = 1'b1; sel = 2'd0; wd = 32'h3500_0000;
    send(PHYS, 32'h0500_0000, 0, "R11 old id used");
    we = 1'b0;
    shadow_write(2'd0, 32'h3500_0000);
    chk_regs("R11 id after");
    send(PHYS, 32'h0500_0000, 0, "R11 new id in force");
    idle();

    // extended mode
    ext = 1'b1;
    @(negedge clk);
    chk_regs("R6 derived");
    chk("R6 derived value", log_o, 32'h0030_0020);
    wr(2'd0, 32'h9900_0000, "R8 id locked");
    wr(2'd1, 32'hFF00_0000, "R8 logical locked");
    wr(2'd2, 32'h0000_0000, "R8 format locked");
    send(LOGI, 32'h0000_0020, 0, "R6 bit hit");
    send(LOGI, 32'h0030_0000, 0, "R6 cluster hit");
    send(LOGI, 32'h0000_0010, 0, "R6 miss");
    send(PHYS, 32'h0000_0035, 0, "R2 ext own id");
    send(PHYS, 32'h3500_0000, 0, "R2 ext top byte");
    send(PHYS, 32'h0000_00FF, 0, "R2 ext broadcast");
    idle();
    ext = 1'b0;
    @(negedge clk);
    chk_regs("R8 legacy restore");

    repeat (2) @(negedge clk);
    chk("R10 drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule